// File: doc/BRIEF.md
# Fast-Data Scan Register with Handshake

This block is a 33-bit test-access data register through which a debug probe finishes a stalled CPU access to the small fast-data window of the debug memory segment. The register holds one status cell at bit 0 and a 32-bit data word above it. When the TAP passes through Capture-DR, the cell records whether an access inside the fast-data window is waiting. If that access is a store, the store data is captured into the word.

The probe shifts all 33 bits, least significant first. It sends a status value of 0 to ask for completion, together with a data word that a waiting load will receive. At Update-DR the register releases the stalled access only if one was waiting at capture time. It then pulses the completion strobe to the debug-segment bridge and, for a load, presents the shifted-in word as the load result.

Because the status bit shifted out tells the probe whether its scan did the transfer, the probe never has to poll before scanning. It scans, checks the bit, and repeats the same word if the bit was 0.

Top module: `fdata_scan_reg`

## Requirements
- R1: After synchronous reset, `tdo`, `acc_done` and `acc_rdata` are all 0.
- R2: With `sel_fd` high, a `capture_dr` cycle loads bit 0 (the status cell) with 1 exactly when `acc_pend` is high and `acc_addr` lies in the fast-data window. Otherwise it loads 0.
- R3: Each `shift_dr` cycle with `sel_fd` high moves the register one place toward bit 0. `tdi` enters at bit 32, and `tdo` always shows bit 0. A full scan is 33 shifts: status first, then data bits 0 through 31.
- R4: At capture, bits 32:1 take `acc_wdata` when the waiting in-window access is a store (`acc_write` = 1). They take all zeros in every other case.
- R5: When a load completes, `acc_rdata` becomes the 32 data bits shifted in, in the same cycle that `acc_done` is high. `acc_rdata` changes at no other time, and a completed store leaves it unchanged.
- R6: An access completes only when status was 1 at the last capture and the status bit held at update is 0. Completion is shown by `acc_done` high for exactly the one cycle after the `update_dr` cycle.
- R7: If nothing was waiting at capture, the update produces no `acc_done` and leaves `acc_rdata` unchanged. This holds even when `acc_pend` rises during the shift.
- R8: If the probe shifts in a status bit of 1, the update completes nothing, even when an access was waiting.
- R9: A waiting access whose address lies outside the window (base `FAST_BASE`, 2^`FAST_SPAN_LOG2` bytes, default 0xFF20_0000 to 0xFF20_000F) captures status 0 and is never completed.
- R10: With `sel_fd` low, `capture_dr`, `shift_dr` and `update_dr` have no effect: `tdo` holds its value and no completion occurs.
- R11: One capture permits at most one completion. A second update without a new capture produces no `acc_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_fd | input | 1 | Instruction register selects this data register |
| capture_dr | input | 1 | TAP is in Capture-DR this cycle |
| shift_dr | input | 1 | TAP is in Shift-DR this cycle |
| update_dr | input | 1 | TAP is in Update-DR this cycle |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (bit 0 of register) |
| acc_pend | input | 1 | Bridge reports a stalled debug-segment access |
| acc_write | input | 1 | Stalled access is a store (1) or load (0) |
| acc_addr | input | ADDR_W | Address of the stalled access |
| acc_wdata | input | DATA_W | Store data of the stalled access |
| acc_done | output | 1 | One-cycle pulse releasing the stalled access |
| acc_rdata | output | DATA_W | Load result for the released access |

## Verification
The hardest case to reach is an access that appears after capture but before update. A naive design that checks pending status at update time would wrongly complete it. The bench has a scan task that can raise `acc_pend` in the middle of the shift phase, which puts the register in exactly that gap. It separately drives a shifted-in status of 1 against a real waiting load, and an update repeated without a fresh capture, so that each gate on completion is exercised on its own.

// File: rtl/fd_pkg.sv
// Shared types for the fast-data scan register.
package fd_pkg;
    // Snapshot of the bridge state taken at Capture-DR.
    typedef struct packed {
        logic hit_pend;   // in-window access was waiting
        logic is_store;   // that access was a store
    } fd_capture_t;
endpackage

// File: rtl/fd_range_match.sv
// Decides whether an address falls in the fast-data window.
// Assumes the window is aligned to its own power-of-two size.
module fd_range_match #(
    parameter int          ADDR_W         = 32,
    parameter logic [31:0] FAST_BASE      = 32'hFF20_0000,
    parameter int          FAST_SPAN_LOG2 = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] BASE_W = ADDR_W'(FAST_BASE);

    generate
        if (FAST_SPAN_LOG2 == 0) begin : g_exact
            // Single-address window: plain equality.
            always_comb hit = (addr == BASE_W);
        end else begin : g_prefix
            localparam logic [ADDR_W-1:0] MASK = ~((ADDR_W'(1) << FAST_SPAN_LOG2) - ADDR_W'(1));
            // Compare the upper bits only.
            always_comb hit = ((addr & MASK) == (BASE_W & MASK));
        end
    endgenerate
endmodule

// File: rtl/fd_shift_chain.sv
// Status-plus-data shift chain. Loads in parallel at capture, shifts
// toward bit 0 with tdi entering at the top, and exposes bit 0 as tdo.
// Assumes load and shift enables are never high together.
module fd_shift_chain #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic              shift_en,
    input  logic              load_status,
    input  logic [DATA_W-1:0] load_data,
    input  logic              tdi,
    output logic              tdo,
    output logic              held_status,
    output logic [DATA_W-1:0] held_data
);
    localparam int LEN = DATA_W + 1;

    logic [LEN-1:0] chain_q;

    // Parallel load at capture, serial shift otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)        chain_q <= '0;
        else if (load_en)  chain_q <= {load_data, load_status};
        else if (shift_en) chain_q <= {tdi, chain_q[LEN-1:1]};
    end

    assign tdo         = chain_q[0];
    assign held_status = chain_q[0];
    assign held_data   = chain_q[LEN-1:1];

    // R3: one shift moves the next bit onto tdo.
    a_r3_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !load_en) |=> (tdo == $past(chain_q[1])));
    // R10: with no enable the chain holds.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !load_en) |=> $stable(chain_q));
endmodule

// File: rtl/fd_complete.sv
// Completion gate. Remembers what capture saw and, at update, releases
// the stalled access only if one was waiting and the probe asked for it.
// Assumes the bridge holds its request until acc_done.
module fd_complete #(
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap_en,
    input  logic               upd_en,
    input  fd_pkg::fd_capture_t cap_in,
    input  logic               held_status,
    input  logic [DATA_W-1:0]  held_data,
    output logic               done,
    output logic [DATA_W-1:0]  rdata
);
    fd_pkg::fd_capture_t armed_q;
    logic                fire;

    // Completion needs a capture-time hit and a probe status of 0.
    always_comb fire = upd_en && armed_q.hit_pend && !held_status;

    // Arm at capture, disarm at any update.
    always_ff @(posedge clk) begin
        if (!rst_n)      armed_q <= '0;
        else if (cap_en) armed_q <= cap_in;
        else if (upd_en) armed_q <= '0;
    end

    // Register the release pulse and the load result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done  <= 1'b0;
            rdata <= '0;
        end else begin
            done <= fire;
            if (fire && !armed_q.is_store) rdata <= held_data;
        end
    end

    // R6: release is a single-cycle pulse.
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6: a pulse always follows an update.
    a_r6_after_update: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(upd_en));
    // R5: load result moves only together with a release.
    a_r5_rdata_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata) |-> done);
    // R11: an update always leaves the gate disarmed.
    a_r11_disarm: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !cap_en) |=> !armed_q.hit_pend);
endmodule

// File: rtl/fdata_scan_reg.sv
// Fast-data scan register top. Joins the window decode, the 33-bit
// chain and the completion gate. TAP strobes count only while sel_fd
// is high. Assumes one TAP state per clock and a single clock domain.
module fdata_scan_reg #(
    parameter int          ADDR_W         = 32,
    parameter int          DATA_W         = 32,
    parameter logic [31:0] FAST_BASE      = 32'hFF20_0000,
    parameter int          FAST_SPAN_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_fd,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic              tdi,
    output logic              tdo,
    input  logic              acc_pend,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              acc_done,
    output logic [DATA_W-1:0] acc_rdata
);
    logic                cap_en, shf_en, upd_en, in_win;
    logic                held_status;
    logic [DATA_W-1:0]   held_data, load_data;
    fd_pkg::fd_capture_t snap;

    // Qualify TAP strobes with the instruction select.
    always_comb begin
        cap_en = sel_fd && capture_dr;
        shf_en = sel_fd && shift_dr && !capture_dr;
        upd_en = sel_fd && update_dr && !capture_dr;
    end

    fd_range_match #(
        .ADDR_W(ADDR_W), .FAST_BASE(FAST_BASE), .FAST_SPAN_LOG2(FAST_SPAN_LOG2)
    ) u_match (
        .addr(acc_addr),
        .hit (in_win)
    );

    // Build the capture snapshot and the upload word.
    always_comb begin
        snap.hit_pend = acc_pend && in_win;
        snap.is_store = acc_write;
        load_data     = (snap.hit_pend && acc_write) ? acc_wdata : '0;
    end

    fd_shift_chain #(.DATA_W(DATA_W)) u_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (cap_en),
        .shift_en   (shf_en),
        .load_status(snap.hit_pend),
        .load_data  (load_data),
        .tdi        (tdi),
        .tdo        (tdo),
        .held_status(held_status),
        .held_data  (held_data)
    );

    fd_complete #(.DATA_W(DATA_W)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_en     (cap_en),
        .upd_en     (upd_en),
        .cap_in     (snap),
        .held_status(held_status),
        .held_data  (held_data),
        .done       (acc_done),
        .rdata      (acc_rdata)
    );

    // R2: the captured status cell reflects an in-window waiting access.
    a_r2_status_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_fd && capture_dr) |=> (tdo == $past(acc_pend && in_win)));
    // R9: an out-of-window access captures status 0.
    a_r9_out_of_window: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_fd && capture_dr && !in_win) |=> !tdo);
    // R10: strobes without select cause no release.
    a_r10_no_sel_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_fd) |=> !acc_done);
endmodule

// File: tb/fdata_scan_reg_bench.sv
module fdata_scan_reg_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_fd = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
    logic        tdo;
    logic        acc_pend = 1'b0, acc_write = 1'b0;
    logic [31:0] acc_addr = 32'h0, acc_wdata = 32'h0;
    logic        acc_done;
    logic [31:0] acc_rdata;

    int checks = 0, errors = 0;
    logic [32:0] scan_out;
    logic        done_seen, done_next;
    logic [31:0] rdata_seen;
    logic        tdo_moved;

    always #(CLK_PERIOD/2) clk = ~clk;

    fdata_scan_reg u_fdata_scan_reg (
        .clk(clk), .rst_n(rst_n), .sel_fd(sel_fd), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
        .acc_pend(acc_pend), .acc_write(acc_write), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_done(acc_done), .acc_rdata(acc_rdata)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Full capture / 33 shifts / update; optional pend raise mid-shift.
    task automatic scan(input logic sel, input logic [32:0] din, input logic raise_mid);
        logic first;
        first = 1'b0;
        tdo_moved = 1'b0;
        @(negedge clk);
        sel_fd = sel; capture_dr = 1'b1;
        @(negedge clk);
        capture_dr = 1'b0; shift_dr = 1'b1;
        for (int i = 0; i < 33; i++) begin
            scan_out[i] = tdo;
            if (i > 0 && tdo !== first) tdo_moved = 1'b1;
            if (i == 0) first = tdo;
            tdi = din[i];
            if (raise_mid && i == 10) acc_pend = 1'b1;
            @(negedge clk);
        end
        shift_dr = 1'b0; update_dr = 1'b1;
        @(negedge clk);
        update_dr = 1'b0;
        done_seen = acc_done;
        rdata_seen = acc_rdata;
        @(negedge clk);
        done_next = acc_done;
        sel_fd = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 tdo", 64'(tdo), 64'd0);
        check("R1 done", 64'(acc_done), 64'd0);
        check("R1 rdata", 64'(acc_rdata), 64'd0);
    endtask

    task automatic t_store;
        acc_pend = 1; acc_write = 1; acc_addr = 32'hFF20_0004; acc_wdata = 32'hA5C3_1E78;
        scan(1, {32'h1111_2222, 1'b0}, 0);
        check("R2 status", 64'(scan_out[0]), 64'd1);
        check("R3 R4 upload data", 64'(scan_out[32:1]), 64'hA5C3_1E78);
        check("R6 done", 64'(done_seen), 64'd1);
        check("R6 pulse width", 64'(done_next), 64'd0);
        check("R5 store keeps rdata", 64'(rdata_seen), 64'd0);
        acc_pend = 0;
    endtask

    task automatic t_load;
        acc_pend = 1; acc_write = 0; acc_addr = 32'hFF20_0000; acc_wdata = 32'hFFFF_FFFF;
        scan(1, {32'hDEAD_BEEF, 1'b0}, 0);
        check("R2 status", 64'(scan_out[0]), 64'd1);
        check("R4 load zero upload", 64'(scan_out[32:1]), 64'd0);
        check("R6 done", 64'(done_seen), 64'd1);
        check("R5 rdata", 64'(rdata_seen), 64'hDEAD_BEEF);
        acc_pend = 0;
    endtask

    task automatic t_idle_then_raise;
        acc_pend = 0; acc_write = 0; acc_addr = 32'hFF20_0008;
        scan(1, {32'h0BAD_0BAD, 1'b0}, 1);
        check("R7 status", 64'(scan_out[0]), 64'd0);
        check("R7 no done", 64'(done_seen), 64'd0);
        check("R7 rdata kept", 64'(rdata_seen), 64'hDEAD_BEEF);
        acc_pend = 0;
    endtask

    task automatic t_status_one;
        acc_pend = 1; acc_write = 0; acc_addr = 32'hFF20_000C;
        scan(1, {32'h1234_5678, 1'b1}, 0);
        check("R8 status out", 64'(scan_out[0]), 64'd1);
        check("R8 no done", 64'(done_seen), 64'd0);
        check("R8 rdata kept", 64'(rdata_seen), 64'hDEAD_BEEF);
        acc_pend = 0;
    endtask

    task automatic t_out_of_window;
        acc_pend = 1; acc_write = 1; acc_addr = 32'hFF20_0010; acc_wdata = 32'hCAFE_F00D;
        scan(1, {32'h5555_AAAA, 1'b0}, 0);
        check("R9 status", 64'(scan_out[0]), 64'd0);
        check("R9 no upload", 64'(scan_out[32:1]), 64'd0);
        check("R9 no done", 64'(done_seen), 64'd0);
        acc_pend = 0;
    endtask

    task automatic t_no_select;
        acc_pend = 1; acc_write = 0; acc_addr = 32'hFF20_0000;
        scan(0, {32'h7777_8888, 1'b0}, 0);
        check("R10 tdo held", 64'(tdo_moved), 64'd0);
        check("R10 no done", 64'(done_seen), 64'd0);
        check("R10 rdata kept", 64'(rdata_seen), 64'hDEAD_BEEF);
        acc_pend = 0;
    endtask

    task automatic t_double_update;
        acc_pend = 1; acc_write = 0; acc_addr = 32'hFF20_0004;
        scan(1, {32'h0F0F_F0F0, 1'b0}, 0);
        check("R11 first done", 64'(done_seen), 64'd1);
        check("R11 first rdata", 64'(rdata_seen), 64'h0F0F_F0F0);
        @(negedge clk);
        sel_fd = 1; update_dr = 1;
        @(negedge clk);
        update_dr = 0;
        check("R11 second update no done", 64'(acc_done), 64'd0);
        sel_fd = 0; acc_pend = 0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_store;
        t_load;
        t_idle_then_raise;
        t_status_one;
        t_out_of_window;
        t_no_select;
        t_double_update;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule